// File: doc/BRIEF.md
# Burst-mode wake-up pulse sequencer

This block is the digital control core of a secondary-side wake-up controller in a flyback converter that runs in burst mode. It watches a digitized switching-activity signal taken from the secondary winding. When that signal has shown no edge for a programmable quiet time, the block concludes that the primary controller has stopped switching. Only at that point does it arm itself and begin to look at its two digitized comparator inputs. One of them signals that the output has sagged below the wake threshold. The other signals that the output has risen above the overvoltage threshold.

Either comparator, once armed, starts a pulse sequence on the switch-drive output. A first gate pulse of fixed width is issued. A snooze window follows. If the converter has not started switching again by the end of that window, one retry pulse of the same width is sent. The block then waits for switching to come back and stop again before it can fire another sequence.

The supply-good input acts as the block's reset. While it is low, the drive output is forced off. An independent limiter makes sure that no gate pulse can ever be longer than the pulse width. All durations are given in microseconds and are converted to clock cycles from a clock-frequency parameter.

Top module: `wake_pulse_seq`

## Requirements
- R1: While `supply_ok` is low, `gate_drive` is 0, `state_code` is 0 (idle) and `last_was_ov` is 0. This takes effect without waiting for a clock edge.
- R2: While `sw_activity` toggles with gaps shorter than the quiet time, `state_code` stays 0 and `gate_drive` stays 0, even with `uv_trip` held high.
- R3: Once `sw_activity` stops changing, `state_code` becomes 1 (armed) no earlier than QUIET cycles after the last change. It does so within QUIET+6 cycles, where QUIET = CLK_MHZ*QUIET_US.
- R4: In the armed state, a high `uv_trip` drives `gate_drive` high for exactly PULSE = CLK_MHZ*PULSE_US cycles, with `state_code` 2 during the pulse.
- R5: After the first pulse, if `sw_activity` stays still, `gate_drive` is low for exactly SNOOZE = CLK_MHZ*SNOOZE_US cycles with `state_code` 3. It is then high for exactly PULSE cycles with `state_code` 4.
- R6: After the second pulse, `state_code` is 5 (done). No further pulse is issued while the trigger stays asserted and `sw_activity` stays still.
- R7: A `sw_activity` change during the snooze window cancels the retry. `state_code` returns to 0 and no second pulse is issued.
- R8: A high `ov_trip` in the armed state runs the same two-pulse sequence as `uv_trip`. `last_was_ov` takes the value 1 when the sequence was started with `ov_trip` high (including both inputs high at once) and 0 when only `uv_trip` started it. The flag keeps that value until the next sequence starts or the supply drops.
- R9: A `sw_activity` change in the armed state or in the done state returns `state_code` to 0. The block re-arms after a new quiet time.
- R10: `gate_drive` is never high for more than PULSE consecutive cycles.
- R11: A `sw_activity` change during a gate pulse has no effect: the pulse keeps its full width and the snooze retry still follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| supply_ok | input | 1 | Supply above turn-on threshold; low acts as asynchronous reset |
| sw_activity | input | 1 | Digitized switching activity from the secondary winding (asynchronous) |
| uv_trip | input | 1 | Wake comparator: output below wake threshold (asynchronous) |
| ov_trip | input | 1 | Overvoltage comparator (asynchronous) |
| gate_drive | output | 1 | Switch-drive output, high during a wake pulse |
| state_code | output | 3 | 0 idle, 1 armed, 2 first pulse, 3 snooze, 4 second pulse, 5 done |
| last_was_ov | output | 1 | Sticky: the most recent sequence was started by overvoltage |

## Verification
The bench builds the block with CLK_MHZ set to 2 and keeps the other defaults. This gives 8-cycle pulses, a 44-cycle snooze window and a 20-cycle quiet time, which are short enough to run many complete sequences with exact cycle counts on pulse width and snooze gap. The comparators use the default level-qualified variant, so the bench reaches the lock-out after the retry with the trigger held high. It also covers cancellation of the retry, activity edges during a pulse and in the armed and done states, and a supply drop in the middle of a pulse.

// File: rtl/wps_pkg.sv
package wps_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_ARMED  = 3'd1,
      ST_PULSE1 = 3'd2,
      ST_SNOOZE = 3'd3,
      ST_PULSE2 = 3'd4,
      ST_DONE   = 3'd5
   } wps_state_e;

   localparam int unsigned NUM_TRIG = 2;
   localparam int unsigned TRIG_UV  = 0;
   localparam int unsigned TRIG_OV  = 1;

endpackage

// File: rtl/wps_rst_sync.sv
module wps_rst_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic arst_n,
   output logic rst_n
);

   logic [STAGES-1:0] shift_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) shift_q <= '0;
      else         shift_q <= {shift_q[STAGES-2:0], 1'b1};
   end

   assign rst_n = shift_q[STAGES-1];

endmodule

// File: rtl/wps_sync.sv
module wps_sync #(
   parameter int unsigned WIDTH  = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[s] <= '0;
            else        stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign q = stage_q[STAGES-1];

endmodule

// File: rtl/wps_quiet_det.sv
module wps_quiet_det #(
   parameter int unsigned QUIET_CYC = 20,
   localparam int unsigned QW       = $clog2(QUIET_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic act_s,
   output logic act_edge,
   output logic quiet
);

   localparam logic [QW-1:0] QLIM = QW'(QUIET_CYC);

   logic          act_prev_q;
   logic [QW-1:0] qcnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) act_prev_q <= 1'b0;
      else        act_prev_q <= act_s;
   end

   assign act_edge = act_s ^ act_prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             qcnt_q <= '0;
      else if (act_edge)      qcnt_q <= '0;
      else if (qcnt_q != QLIM) qcnt_q <= qcnt_q + 1'b1;
   end

   assign quiet = (qcnt_q == QLIM);

endmodule

// File: rtl/wps_trig_qual.sv
module wps_trig_qual #(
   parameter bit LEVEL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic hit
);

   if (LEVEL) begin : g_level
      assign hit = lvl;
   end else begin : g_edge
      logic prev_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= lvl;
      end
      assign hit = lvl & ~prev_q;
   end

endmodule

// File: rtl/wps_seq_fsm.sv
module wps_seq_fsm
   import wps_pkg::*;
#(
   parameter int unsigned PULSE_CYC  = 8,
   parameter int unsigned SNOOZE_CYC = 44,
   localparam int unsigned MAXC      = (PULSE_CYC > SNOOZE_CYC) ? PULSE_CYC : SNOOZE_CYC,
   localparam int unsigned CW        = $clog2(MAXC + 1)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       quiet,
   input  logic       act_edge,
   input  logic       uv_hit,
   input  logic       ov_hit,
   output logic       gate_req,
   output wps_state_e state,
   output logic       ov_flag
);

   localparam logic [CW-1:0] PEND = CW'(PULSE_CYC - 1);
   localparam logic [CW-1:0] SEND = CW'(SNOOZE_CYC - 1);

   wps_state_e    state_q, state_d;
   logic [CW-1:0] cnt_q;
   logic          ov_q;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:   if (quiet) state_d = ST_ARMED;
         ST_ARMED: begin
            if (act_edge)             state_d = ST_IDLE;
            else if (uv_hit || ov_hit) state_d = ST_PULSE1;
         end
         ST_PULSE1: if (cnt_q == PEND) state_d = ST_SNOOZE;
         ST_SNOOZE: begin
            if (act_edge)          state_d = ST_IDLE;
            else if (cnt_q == SEND) state_d = ST_PULSE2;
         end
         ST_PULSE2: if (cnt_q == PEND) state_d = ST_DONE;
         ST_DONE:   if (act_edge) state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   cnt_q <= '0;
      else if (state_d != state_q)  cnt_q <= '0;
      else if (state_q == ST_PULSE1 || state_q == ST_SNOOZE || state_q == ST_PULSE2)
                                    cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ov_q <= 1'b0;
      else if (state_q == ST_ARMED && state_d == ST_PULSE1) ov_q <= ov_hit;
   end

   assign gate_req = (state_q == ST_PULSE1) || (state_q == ST_PULSE2);
   assign state    = state_q;
   assign ov_flag  = ov_q;

endmodule

// File: rtl/wps_gate_limit.sv
module wps_gate_limit #(
   parameter int unsigned PULSE_CYC = 8,
   localparam int unsigned LW       = $clog2(PULSE_CYC + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic gate
);

   localparam logic [LW-1:0] LLIM = LW'(PULSE_CYC);

   logic [LW-1:0] run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             run_q <= '0;
      else if (!req)          run_q <= '0;
      else if (run_q != LLIM) run_q <= run_q + 1'b1;
   end

   assign gate = req && (run_q < LLIM);

endmodule

// File: rtl/wake_pulse_seq.sv
module wake_pulse_seq
   import wps_pkg::*;
#(
   parameter int unsigned CLK_MHZ     = 125,
   parameter int unsigned PULSE_US    = 4,
   parameter int unsigned SNOOZE_US   = 22,
   parameter int unsigned QUIET_US    = 10,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          TRIG_LEVEL  = 1'b1
) (
   input  logic       clk,
   input  logic       supply_ok,
   input  logic       sw_activity,
   input  logic       uv_trip,
   input  logic       ov_trip,
   output logic       gate_drive,
   output logic [2:0] state_code,
   output logic       last_was_ov
);

   localparam int unsigned PULSE_CYC  = CLK_MHZ * PULSE_US;
   localparam int unsigned SNOOZE_CYC = CLK_MHZ * SNOOZE_US;
   localparam int unsigned QUIET_CYC  = CLK_MHZ * QUIET_US;

   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("wake_pulse_seq: pulse width must be at least one cycle");
   end
   if (SNOOZE_CYC < 1) begin : g_bad_snooze
      $error("wake_pulse_seq: snooze window must be at least one cycle");
   end
   if (QUIET_CYC < 2) begin : g_bad_quiet
      $error("wake_pulse_seq: quiet time must be at least two cycles");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("wake_pulse_seq: synchronizer needs two or more stages");
   end

   logic                rst_n;
   logic [NUM_TRIG:0]   raw_in, sync_out;
   logic [NUM_TRIG-1:0] hit;
   logic                act_edge, quiet, gate_req, gate_lim, ov_flag;
   wps_state_e          state;

   wps_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
      .clk    (clk),
      .arst_n (supply_ok),
      .rst_n  (rst_n)
   );

   assign raw_in = {ov_trip, uv_trip, sw_activity};

   wps_sync #(.WIDTH(NUM_TRIG + 1), .STAGES(SYNC_STAGES)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (raw_in),
      .q     (sync_out)
   );

   wps_quiet_det #(.QUIET_CYC(QUIET_CYC)) i_quiet (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_s    (sync_out[0]),
      .act_edge (act_edge),
      .quiet    (quiet)
   );

   for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
      wps_trig_qual #(.LEVEL(TRIG_LEVEL)) i_qual (
         .clk   (clk),
         .rst_n (rst_n),
         .lvl   (sync_out[t+1]),
         .hit   (hit[t])
      );
   end

   wps_seq_fsm #(.PULSE_CYC(PULSE_CYC), .SNOOZE_CYC(SNOOZE_CYC)) i_fsm (
      .clk      (clk),
      .rst_n    (rst_n),
      .quiet    (quiet),
      .act_edge (act_edge),
      .uv_hit   (hit[TRIG_UV]),
      .ov_hit   (hit[TRIG_OV]),
      .gate_req (gate_req),
      .state    (state),
      .ov_flag  (ov_flag)
   );

   wps_gate_limit #(.PULSE_CYC(PULSE_CYC)) i_limit (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (gate_req),
      .gate  (gate_lim)
   );

   assign gate_drive  = gate_lim & supply_ok;
   assign state_code  = state;
   assign last_was_ov = ov_flag;

endmodule

// File: rtl/wps_chk.sv
module wps_chk #(
   parameter int unsigned PULSE_CYC = 8
) (
   input logic       clk,
   input logic       supply_ok,
   input logic       gate_drive,
   input logic [2:0] state_code
);

   localparam int unsigned RW = $clog2(PULSE_CYC + 2);

   logic [RW-1:0] run_cnt;

   always_ff @(posedge clk or negedge supply_ok) begin
      if (!supply_ok)                         run_cnt <= '0;
      else if (!gate_drive)                   run_cnt <= '0;
      else if (run_cnt != RW'(PULSE_CYC + 1)) run_cnt <= run_cnt + 1'b1;
   end

   // R10: pulse length bounded
   a_r10_gate_limit: assert property (@(posedge clk) disable iff (!supply_ok)
      gate_drive |-> (run_cnt < RW'(PULSE_CYC)));

   // R1: output off without supply
   a_r1_gate_off: assert property (@(posedge clk)
      !supply_ok |-> !gate_drive);

   // R4: gate only in a pulse state
   a_r4_gate_state: assert property (@(posedge clk) disable iff (!supply_ok)
      gate_drive |-> (state_code == 3'd2 || state_code == 3'd4));

   // R3: armed is only entered from idle
   a_r3_arm_from_idle: assert property (@(posedge clk) disable iff (!supply_ok)
      (state_code == 3'd1 && $past(state_code) != 3'd1) |-> ($past(state_code) == 3'd0));

   // R5: second pulse only after snooze
   a_r5_retry_after_snooze: assert property (@(posedge clk) disable iff (!supply_ok)
      (state_code == 3'd4 && $past(state_code) != 3'd4) |-> ($past(state_code) == 3'd3));

   // R6: done leaves only to idle
   a_r6_done_exit: assert property (@(posedge clk) disable iff (!supply_ok)
      (state_code == 3'd5) |=> (state_code == 3'd5 || state_code == 3'd0));

endmodule

bind wake_pulse_seq wps_chk #(.PULSE_CYC(PULSE_CYC)) i_wps_chk (
   .clk        (clk),
   .supply_ok  (supply_ok),
   .gate_drive (gate_drive),
   .state_code (state_code)
);

// File: tb/test_wake_pulse_seq.sv
module test_wake_pulse_seq;

   localparam int unsigned CLK_MHZ = 2;
   localparam int PULSE  = CLK_MHZ * 4;
   localparam int SNOOZE = CLK_MHZ * 22;
   localparam int QUIET  = CLK_MHZ * 10;

   logic       clk = 1'b0;
   logic       supply_ok = 1'b0;
   logic       sw_activity = 1'b0;
   logic       uv_trip = 1'b0;
   logic       ov_trip = 1'b0;
   logic       gate_drive;
   logic [2:0] state_code;
   logic       last_was_ov;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   wake_pulse_seq #(.CLK_MHZ(CLK_MHZ)) i_wake_pulse_seq (
      .clk         (clk),
      .supply_ok   (supply_ok),
      .sw_activity (sw_activity),
      .uv_trip     (uv_trip),
      .ov_trip     (ov_trip),
      .gate_drive  (gate_drive),
      .state_code  (state_code),
      .last_was_ov (last_was_ov)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic toggle_act();
      sw_activity = ~sw_activity;
      @(negedge clk);
   endtask

   task automatic wait_state(input logic [2:0] code, input int max, output int n);
      n = 0;
      while (state_code !== code && n < max) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic wait_gate(input int max, output int n);
      n = 0;
      while (gate_drive !== 1'b1 && n < max) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic run_high(output int n);
      n = 0;
      while (gate_drive === 1'b1 && n < 1000) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic rearm();
      int n;
      toggle_act();
      wait_state(3'd1, QUIET + 20, n);
   endtask

   // full two-pulse sequence from the armed state with the trigger already set
   task automatic seq_check(input bit exp_flag, input string tag);
      int n, w, gap, w2, st;
      bit stray;
      wait_gate(20, n);
      check(gate_drive === 1'b1, {"R4 first pulse starts ", tag}, n, 20);
      st = int'(state_code);
      check(st == 2, {"R4 state in first pulse ", tag}, st, 2);
      run_high(w);
      check(w == PULSE, {"R4 R10 first pulse width ", tag}, w, PULSE);
      st = int'(state_code);
      check(st == 3, {"R5 snooze state ", tag}, st, 3);
      gap = 0;
      while (gate_drive !== 1'b1 && gap < 1000) begin
         @(negedge clk);
         gap++;
      end
      check(gap == SNOOZE, {"R5 snooze gap ", tag}, gap, SNOOZE);
      st = int'(state_code);
      check(st == 4, {"R5 state in second pulse ", tag}, st, 4);
      run_high(w2);
      check(w2 == PULSE, {"R5 R10 second pulse width ", tag}, w2, PULSE);
      st = int'(state_code);
      check(st == 5, {"R6 done state ", tag}, st, 5);
      stray = 1'b0;
      for (int i = 0; i < 100; i++) begin
         @(negedge clk);
         if (gate_drive !== 1'b0 || state_code !== 3'd5) stray = 1'b1;
      end
      check(!stray, {"R6 no pulse after retry ", tag}, int'(stray), 0);
      check(last_was_ov === exp_flag, {"R8 overvoltage flag ", tag},
            int'(last_was_ov), int'(exp_flag));
   endtask

   task automatic t_reset();
      tick(5);
      check(gate_drive === 1'b0, "R1 gate at reset", int'(gate_drive), 0);
      check(state_code === 3'd0, "R1 state at reset", int'(state_code), 0);
      check(last_was_ov === 1'b0, "R1 flag at reset", int'(last_was_ov), 0);
   endtask

   task automatic t_switching_then_uv();
      bit seen;
      int n;
      supply_ok = 1'b1;
      uv_trip = 1'b1;
      seen = 1'b0;
      for (int k = 0; k < 15; k++) begin
         toggle_act();
         for (int j = 0; j < 4; j++) begin
            if (state_code !== 3'd0 || gate_drive !== 1'b0) seen = 1'b1;
            @(negedge clk);
         end
      end
      check(!seen, "R2 comparators ignored while switching", int'(seen), 0);
      wait_state(3'd1, QUIET + 20, n);
      n = n + 4;
      check(state_code === 3'd1 && n >= QUIET && n <= QUIET + 6,
            "R3 arm delay after last edge", n, QUIET);
      seq_check(1'b0, "uv");
      uv_trip = 1'b0;
   endtask

   task automatic t_rearm_paths();
      int n;
      toggle_act();
      tick(6);
      check(state_code === 3'd0, "R9 done to idle on edge", int'(state_code), 0);
      wait_state(3'd1, QUIET + 20, n);
      check(state_code === 3'd1, "R9 re-armed after quiet", int'(state_code), 1);
      toggle_act();
      tick(6);
      check(state_code === 3'd0, "R9 armed to idle on edge", int'(state_code), 0);
      wait_state(3'd1, QUIET + 20, n);
      check(state_code === 3'd1, "R9 re-armed again", int'(state_code), 1);
   endtask

   task automatic t_ov();
      ov_trip = 1'b1;
      seq_check(1'b1, "ov");
      ov_trip = 1'b0;
   endtask

   task automatic t_cancel();
      int n, w;
      bit seen;
      rearm();
      uv_trip = 1'b1;
      wait_gate(20, n);
      run_high(w);
      uv_trip = 1'b0;
      tick(10);
      check(state_code === 3'd3, "R7 in snooze before edge", int'(state_code), 3);
      toggle_act();
      tick(6);
      check(state_code === 3'd0, "R7 snooze cancelled to idle", int'(state_code), 0);
      seen = 1'b0;
      for (int i = 0; i < 60; i++) begin
         @(negedge clk);
         if (gate_drive !== 1'b0) seen = 1'b1;
      end
      check(!seen, "R7 no retry pulse after cancel", int'(seen), 0);
   endtask

   task automatic t_edge_in_pulse();
      int n, w;
      wait_state(3'd1, QUIET + 20, n);
      uv_trip = 1'b1;
      wait_gate(20, n);
      w = 0;
      while (gate_drive === 1'b1 && w < 1000) begin
         if (w == 3) sw_activity = ~sw_activity;
         @(negedge clk);
         w++;
      end
      check(w == PULSE, "R11 pulse width with edge inside", w, PULSE);
      wait_state(3'd4, SNOOZE + 10, n);
      check(state_code === 3'd4, "R11 retry still follows", int'(state_code), 4);
      wait_state(3'd5, PULSE + 10, n);
      uv_trip = 1'b0;
   endtask

   task automatic t_both_then_uv();
      rearm();
      uv_trip = 1'b1;
      ov_trip = 1'b1;
      seq_check(1'b1, "both");
      uv_trip = 1'b0;
      ov_trip = 1'b0;
      rearm();
      uv_trip = 1'b1;
      seq_check(1'b0, "uv after ov");
      uv_trip = 1'b0;
   endtask

   task automatic t_supply_drop();
      int n;
      rearm();
      ov_trip = 1'b1;
      wait_gate(20, n);
      tick(2);
      check(last_was_ov === 1'b1, "R8 flag set before drop", int'(last_was_ov), 1);
      supply_ok = 1'b0;
      #1;
      check(gate_drive === 1'b0, "R1 gate off on supply drop", int'(gate_drive), 0);
      check(state_code === 3'd0, "R1 state idle on supply drop", int'(state_code), 0);
      check(last_was_ov === 1'b0, "R1 flag cleared on supply drop", int'(last_was_ov), 0);
      ov_trip = 1'b0;
      tick(3);
      supply_ok = 1'b1;
      tick(3);
   endtask

   initial begin
      t_reset();
      t_switching_then_uv();
      t_rearm_paths();
      t_ov();
      t_cancel();
      t_edge_in_pulse();
      t_both_then_uv();
      t_supply_drop();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule